// File: doc/BRIEF.md
# PLL Self-Calibration Sequencer

This controller runs the self-calibration of a frequency synthesizer. The analog VCO, charge pump and loop filter stay outside it. Software writes a start bit together with a wait code, a nominal tuning level, a channel select and a dual-calibration request. The block then holds the analog loop in calibration for a programmable number of reference-clock ticks and samples the loop's lock indication. When lock is seen, it stores the tuning code that the loop reports.

Two frequency channels, A and B, each keep their own stored result. One calibration may serve both channels, but only when their frequency words, reference dividers and VCO current settings are compatible. A dual request that fails this check falls back to calibrating only the selected channel and leaves a sticky flag. When lock does not come, the sequence repeats until it does. A programmable attempt limit ends a hopeless run with a failure flag. A 4-bit select field routes either the completion flag or the continuous lock status to a single pin.

Top module: `pll_cal_seq`

## Requirements
- R1: A one-cycle pulse on `cal_start_i` while idle sets `start_bit_o` on the next clock edge. On the edge after that, the sequence begins: `busy_o` rises and `start_bit_o` returns to 0.
- R2: A start pulse applied while `busy_o` is high is ignored. `start_bit_o` stays 0, and no additional calibration follows the running one.
- R3: Each attempt waits N × `WAIT_SCALE` ticks of `ref_tick_i`, where N is 49, 60, 71 or 109 for wait code 00, 01, 10 or 11.
- R4: `cal_complete_o` is 0 out of reset and is cleared when a sequence begins. It is set when an attempt ends with `lock_i` high.
- R5: `lock_pin_o` shows `cal_complete_o` when `lock_sel_i` is 4'b0101 and `lock_cont_o` when it is 4'b0010. For every other code it is 0.
- R6: `lock_cont_o` equals `lock_i` delayed by one clock.
- R7: In separate mode, a successful calibration writes `vco_code_i` into the result of the channel picked by `chan_sel_i` (0 = A, 1 = B) and sets that channel's valid flag. The other channel's result and flag are unchanged.
- R8: With `dual_i` set, the calibration writes the same code to both channels when all of these hold: the frequency words differ by less than `FREQ_TOL`, the reference dividers are equal, and the VCO currents are equal.
- R9: A dual request that fails the compatibility check runs as a separate calibration of the selected channel. It also sets `dual_rej_o`, which stays set until reset.
- R10: When an attempt ends without lock, a new wait starts at once and `busy_o` stays high until lock is seen.
- R11: After max(`retry_max_i`, 1) attempts without lock, the sequence stops. It sets `cal_fail_o`, leaves `cal_complete_o` at 0 and writes no result. `cal_fail_o` is cleared when a new sequence begins.
- R12: Out of reset, all results and valid flags are 0. Stored results change only at the end of a successful calibration.
- R13: `vctrl_nom_o` holds the `iterate_i` value captured when the last sequence began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_start_i | input | 1 | Write of 1 to the start bit |
| wait_sel_i | input | 2 | Wait code |
| iterate_i | input | 3 | Nominal VCO control level |
| dual_i | input | 1 | Request one calibration for both channels |
| chan_sel_i | input | 1 | Operating channel, 0 = A, 1 = B |
| retry_max_i | input | RETRY_W | Attempt limit, 0 acts as 1 |
| ref_tick_i | input | 1 | One pulse per internal reference period |
| freq_a_i | input | FREQ_W | Channel A frequency word |
| freq_b_i | input | FREQ_W | Channel B frequency word |
| ref_div_a_i | input | DIV_W | Channel A reference divider |
| ref_div_b_i | input | DIV_W | Channel B reference divider |
| vco_cur_a_i | input | VCUR_W | Channel A VCO current |
| vco_cur_b_i | input | VCUR_W | Channel B VCO current |
| lock_i | input | 1 | Lock indication from the analog loop |
| vco_code_i | input | RES_W | Tuning code reported by the analog loop |
| lock_sel_i | input | 4 | Lock pin source select |
| start_bit_o | output | 1 | Start bit readback |
| busy_o | output | 1 | Sequence running |
| cal_complete_o | output | 1 | Calibration finished with lock |
| cal_fail_o | output | 1 | Attempt limit exhausted |
| dual_rej_o | output | 1 | Sticky: dual request rejected |
| lock_cont_o | output | 1 | Continuous lock status |
| lock_pin_o | output | 1 | Multiplexed lock pin |
| vctrl_nom_o | output | 3 | Captured nominal control level |
| res_valid_a_o | output | 1 | Channel A result valid |
| res_a_o | output | RES_W | Channel A stored code |
| res_valid_b_o | output | 1 | Channel B result valid |
| res_b_o | output | RES_W | Channel B stored code |

## Verification
A miscounted wait timer shows up in the length of the `busy_o` pulse. That length is checked against the tick count of every wait code, one attempt at a time, so the error appears within the first calibration that uses the affected code. A wrong compatibility decision or channel steering shows up as a wrong result, a wrong valid flag or a wrong `dual_rej_o` value. These are compared after every calibration in a random run. A broken retry path shows up as the wrong number of attempt lengths, or as a wrong complete/fail pair, by the end of that sequence.

// File: rtl/pll_cal_pkg.sv
package pll_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CHECK = 2'd2
  } cal_state_e;

  localparam int unsigned MaxUnits = 109;

  localparam logic [3:0] PinSelDone = 4'b0101;
  localparam logic [3:0] PinSelLock = 4'b0010;

  function automatic logic [6:0] wait_units(input logic [1:0] code);
    case (code)
      2'b00:   wait_units = 7'd49;
      2'b01:   wait_units = 7'd60;
      2'b10:   wait_units = 7'd71;
      default: wait_units = 7'd109;
    endcase
  endfunction

endpackage

// File: rtl/cal_wait_timer.sv
module cal_wait_timer
  import pll_cal_pkg::*;
#(
  parameter int unsigned WAIT_SCALE = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] wait_sel_i,
  input  logic       tick_i,
  output logic       expired_o
);
  localparam int unsigned MaxCnt = MaxUnits * WAIT_SCALE;
  localparam int unsigned CntW   = $clog2(MaxCnt + 1);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CntW'(int'(wait_units(wait_sel_i)) * int'(WAIT_SCALE));
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= int'(MaxCnt));
  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cal_dual_check.sv
module cal_dual_check #(
  parameter int unsigned FREQ_W   = 20,
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned VCUR_W   = 4,
  parameter int unsigned FREQ_TOL = 1000
) (
  input  logic [FREQ_W-1:0] freq_a_i,
  input  logic [FREQ_W-1:0] freq_b_i,
  input  logic [DIV_W-1:0]  div_a_i,
  input  logic [DIV_W-1:0]  div_b_i,
  input  logic [VCUR_W-1:0] cur_a_i,
  input  logic [VCUR_W-1:0] cur_b_i,
  output logic              compat_o
);
  logic [FREQ_W-1:0] gap;

  always_comb begin
    gap = (freq_a_i >= freq_b_i) ? (freq_a_i - freq_b_i) : (freq_b_i - freq_a_i);
    compat_o = (int'(gap) < int'(FREQ_TOL)) && (div_a_i == div_b_i) && (cur_a_i == cur_b_i);
  end

endmodule

// File: rtl/cal_lock_mux.sv
module cal_lock_mux
  import pll_cal_pkg::*;
(
  input  logic [3:0] sel_i,
  input  logic       done_i,
  input  logic       lock_i,
  output logic       pin_o
);
  always_comb begin
    case (sel_i)
      PinSelDone: pin_o = done_i;
      PinSelLock: pin_o = lock_i;
      default:    pin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pll_cal_seq.sv
module pll_cal_seq
  import pll_cal_pkg::*;
#(
  parameter int unsigned FREQ_W     = 20,
  parameter int unsigned DIV_W      = 3,
  parameter int unsigned VCUR_W     = 4,
  parameter int unsigned RES_W      = 6,
  parameter int unsigned RETRY_W    = 4,
  parameter int unsigned WAIT_SCALE = 2,
  parameter int unsigned FREQ_TOL   = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cal_start_i,
  input  logic [1:0]         wait_sel_i,
  input  logic [2:0]         iterate_i,
  input  logic               dual_i,
  input  logic               chan_sel_i,
  input  logic [RETRY_W-1:0] retry_max_i,
  input  logic               ref_tick_i,
  input  logic [FREQ_W-1:0]  freq_a_i,
  input  logic [FREQ_W-1:0]  freq_b_i,
  input  logic [DIV_W-1:0]   ref_div_a_i,
  input  logic [DIV_W-1:0]   ref_div_b_i,
  input  logic [VCUR_W-1:0]  vco_cur_a_i,
  input  logic [VCUR_W-1:0]  vco_cur_b_i,
  input  logic               lock_i,
  input  logic [RES_W-1:0]   vco_code_i,
  input  logic [3:0]         lock_sel_i,
  output logic               start_bit_o,
  output logic               busy_o,
  output logic               cal_complete_o,
  output logic               cal_fail_o,
  output logic               dual_rej_o,
  output logic               lock_cont_o,
  output logic               lock_pin_o,
  output logic [2:0]         vctrl_nom_o,
  output logic               res_valid_a_o,
  output logic [RES_W-1:0]   res_a_o,
  output logic               res_valid_b_o,
  output logic [RES_W-1:0]   res_b_o
);
  cal_state_e         state_q;
  logic               start_q, done_q, fail_q, rej_q, lock_q;
  logic               chan_q, dual_q;
  logic [1:0]         wsel_q;
  logic [2:0]         iter_q;
  logic [RETRY_W-1:0] limit_q, tries_q;
  logic               val_a_q, val_b_q;
  logic [RES_W-1:0]   res_a_q, res_b_q;

  logic       compat, expired, launch, retry, tmr_load, out_of_tries;
  logic [1:0] tmr_sel;

  cal_dual_check #(
    .FREQ_W(FREQ_W), .DIV_W(DIV_W), .VCUR_W(VCUR_W), .FREQ_TOL(FREQ_TOL)
  ) u_compat (
    .freq_a_i(freq_a_i), .freq_b_i(freq_b_i),
    .div_a_i (ref_div_a_i), .div_b_i(ref_div_b_i),
    .cur_a_i (vco_cur_a_i), .cur_b_i(vco_cur_b_i),
    .compat_o(compat)
  );

  assign launch       = (state_q == ST_IDLE) && start_q;
  assign out_of_tries = (tries_q >= limit_q);
  assign retry        = (state_q == ST_CHECK) && !lock_i && !out_of_tries;
  assign tmr_load     = launch || retry;
  assign tmr_sel      = launch ? wait_sel_i : wsel_q;

  cal_wait_timer #(.WAIT_SCALE(WAIT_SCALE)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .wait_sel_i(tmr_sel),
    .tick_i    (ref_tick_i),
    .expired_o (expired)
  );

  // start bit: set only while idle, cleared when the sequence launches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      start_q <= start_q ? 1'b0 : cal_start_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      rej_q   <= 1'b0;
      chan_q  <= 1'b0;
      dual_q  <= 1'b0;
      wsel_q  <= 2'b11;
      iter_q  <= '0;
      limit_q <= '0;
      tries_q <= '0;
      val_a_q <= 1'b0;
      val_b_q <= 1'b0;
      res_a_q <= '0;
      res_b_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_WAIT;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          chan_q  <= chan_sel_i;
          dual_q  <= dual_i && compat;
          wsel_q  <= wait_sel_i;
          iter_q  <= iterate_i;
          limit_q <= (retry_max_i == '0) ? RETRY_W'(1) : retry_max_i;
          tries_q <= RETRY_W'(1);
          if (dual_i && !compat) rej_q <= 1'b1;
        end
        ST_WAIT: if (expired) state_q <= ST_CHECK;
        ST_CHECK: begin
          if (lock_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (dual_q || !chan_q) begin
              res_a_q <= vco_code_i;
              val_a_q <= 1'b1;
            end
            if (dual_q || chan_q) begin
              res_b_q <= vco_code_i;
              val_b_q <= 1'b1;
            end
          end else if (out_of_tries) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
            tries_q <= tries_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_i;
  end

  cal_lock_mux u_pin (
    .sel_i (lock_sel_i),
    .done_i(done_q),
    .lock_i(lock_q),
    .pin_o (lock_pin_o)
  );

  assign start_bit_o    = start_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign cal_complete_o = done_q;
  assign cal_fail_o     = fail_q;
  assign dual_rej_o     = rej_q;
  assign lock_cont_o    = lock_q;
  assign vctrl_nom_o    = iter_q;
  assign res_valid_a_o  = val_a_q;
  assign res_a_o        = res_a_q;
  assign res_valid_b_o  = val_b_q;
  assign res_b_o        = res_b_q;

  p_start_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_q) |=> (!start_q && busy_o));
  p_busy_blocks_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_q);
  p_done_fail_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && fail_q));
  p_res_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(res_a_q) && $stable(res_b_q)));
  p_rej_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_q |=> rej_q);
  p_lock_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lock_cont_o == $past(lock_i)));
  p_pin_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_sel_i != PinSelDone && lock_sel_i != PinSelLock) |-> !lock_pin_o);
  p_done_needs_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(lock_i));

endmodule

// File: tb/sim_pll_cal_seq.sv
module sim_pll_cal_seq;
  localparam int FREQ_W = 20, DIV_W = 3, VCUR_W = 4, RES_W = 6, RETRY_W = 4;
  localparam int SCALE = 2, TOL = 1000, TICK_P = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cal_start_i = 0, dual_i = 0, chan_sel_i = 0, ref_tick_i = 0, lock_i = 0;
  logic [1:0] wait_sel_i = 2'b11;
  logic [2:0] iterate_i = '0;
  logic [RETRY_W-1:0] retry_max_i = 4'd3;
  logic [FREQ_W-1:0] freq_a_i = '0, freq_b_i = '0;
  logic [DIV_W-1:0] ref_div_a_i = '0, ref_div_b_i = '0;
  logic [VCUR_W-1:0] vco_cur_a_i = '0, vco_cur_b_i = '0;
  logic [RES_W-1:0] vco_code_i = '0;
  logic [3:0] lock_sel_i = 4'b0101;
  logic start_bit_o, busy_o, cal_complete_o, cal_fail_o, dual_rej_o, lock_cont_o, lock_pin_o;
  logic [2:0] vctrl_nom_o;
  logic res_valid_a_o, res_valid_b_o;
  logic [RES_W-1:0] res_a_o, res_b_o;

  pll_cal_seq #(.FREQ_W(FREQ_W), .DIV_W(DIV_W), .VCUR_W(VCUR_W), .RES_W(RES_W),
    .RETRY_W(RETRY_W), .WAIT_SCALE(SCALE), .FREQ_TOL(TOL)) u0 (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0, busy_cnt = 0, lock_after = 0;
  bit m_va = 0, m_vb = 0, m_rej = 0;
  int m_ra = 0, m_rb = 0;

  // reference tick and analog-loop stub
  always @(negedge clk_i) begin
    cyc++;
    ref_tick_i = (cyc % TICK_P) == 0;
    if (busy_o) busy_cnt++; else busy_cnt = 0;
    lock_i = (busy_cnt >= lock_after);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int units(input logic [1:0] c);
    case (c) 2'b00: return 49; 2'b01: return 60; 2'b10: return 71; default: return 109; endcase
  endfunction

  function automatic bit compat_ok();
    int d = int'(freq_a_i) - int'(freq_b_i);
    if (d < 0) d = -d;
    return (d < TOL) && (ref_div_a_i == ref_div_b_i) && (vco_cur_a_i == vco_cur_b_i);
  endfunction

  // start a sequence and return the number of busy cycles
  task automatic run_cal(output int busy_len);
    @(negedge clk_i); cal_start_i = 1;
    @(negedge clk_i); cal_start_i = 0;
    check("R1 start bit set", int'(start_bit_o), 1);
    @(negedge clk_i);
    check("R1 start bit clears on launch", int'(start_bit_o), 0);
    check("R1 busy on launch", int'(busy_o), 1);
    busy_len = 1;
    while (busy_o) begin @(negedge clk_i); if (busy_o) busy_len++; end
  endtask

  task automatic check_len(string req, int len, int d, int n);
    n_chk++;
    if (len < n * (TICK_P * d - TICK_P) || len > n * (TICK_P * d + TICK_P)) begin
      n_bad++;
      $display("FAIL %s: actual %0d cycles expected about %0d", req, len, n * TICK_P * d);
    end
  endtask

  task automatic check_state(string tag);
    check({tag, " R7 valid A"}, int'(res_valid_a_o), int'(m_va));
    check({tag, " R7 valid B"}, int'(res_valid_b_o), int'(m_vb));
    check({tag, " R8 result A"}, int'(res_a_o), m_ra);
    check({tag, " R8 result B"}, int'(res_b_o), m_rb);
    check({tag, " R9 dual reject"}, int'(dual_rej_o), int'(m_rej));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int len, d;
    bit ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R12 reset valid A", int'(res_valid_a_o), 0);
    check("R12 reset result B", int'(res_b_o), 0);
    check("R4 reset complete", int'(cal_complete_o), 0);
    check("R5 pin select 0101 at reset", int'(lock_pin_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R3: each wait code, locked at first look, channel A separate
    for (int c = 0; c < 4; c++) begin
      wait_sel_i = 2'(c); iterate_i = 3'(c + 2); vco_code_i = 6'(10 + c);
      lock_after = 0; chan_sel_i = 0; dual_i = 0;
      run_cal(len);
      check_len($sformatf("R3 code %0d", c), len, units(2'(c)) * SCALE, 1);
      check("R4 complete", int'(cal_complete_o), 1);
      check("R13 nominal level", int'(vctrl_nom_o), c + 2);
      m_va = 1; m_ra = 10 + c;
      check_state("R7 sep A");
    end

    // R5/R6: pin mux and lock delay
    lock_sel_i = 4'b0101; @(negedge clk_i);
    check("R5 pin shows complete", int'(lock_pin_o), 1);
    lock_after = 1; @(negedge clk_i); @(negedge clk_i);
    check("R6 lock low", int'(lock_cont_o), 0);
    lock_sel_i = 4'b0010; @(negedge clk_i);
    check("R5 pin shows lock low", int'(lock_pin_o), 0);
    lock_after = 0; @(negedge clk_i); @(negedge clk_i);
    check("R6 lock high", int'(lock_cont_o), 1);
    check("R5 pin shows lock high", int'(lock_pin_o), 1);
    lock_sel_i = 4'b0000; @(negedge clk_i);
    check("R5 pin off for other codes", int'(lock_pin_o), 0);
    lock_sel_i = 4'b0101;

    // R10: lock arrives during second attempt
    wait_sel_i = 2'b00; d = units(2'b00) * SCALE;
    lock_after = TICK_P * d + TICK_P * d / 2; chan_sel_i = 1; vco_code_i = 6'd33;
    run_cal(len);
    check_len("R10 two attempts", len, d, 2);
    check("R10 complete after retry", int'(cal_complete_o), 1);
    m_vb = 1; m_rb = 33;
    check_state("R10");

    // R11: never locks, limit 3 then limit 0
    lock_after = 1000000000; retry_max_i = 4'd3; vco_code_i = 6'd50;
    run_cal(len);
    check_len("R11 three attempts", len, d, 3);
    check("R11 fail flag", int'(cal_fail_o), 1);
    check("R11 no complete", int'(cal_complete_o), 0);
    check_state("R11");
    retry_max_i = 4'd0;
    run_cal(len);
    check_len("R11 limit zero acts as one", len, d, 1);
    check("R11 fail flag again", int'(cal_fail_o), 1);
    retry_max_i = 4'd3;

    // R2: start while busy ignored
    lock_after = 0; wait_sel_i = 2'b01; d = units(2'b01) * SCALE; vco_code_i = 6'd7; chan_sel_i = 0;
    @(negedge clk_i); cal_start_i = 1;
    @(negedge clk_i); cal_start_i = 0;
    @(negedge clk_i); repeat (20) @(negedge clk_i);
    cal_start_i = 1; @(negedge clk_i); cal_start_i = 0; @(negedge clk_i);
    check("R2 start bit stays clear while busy", int'(start_bit_o), 0);
    while (busy_o) @(negedge clk_i);
    check("R11 fail cleared by new run", int'(cal_fail_o), 0);
    repeat (3) @(negedge clk_i);
    check("R2 no second run", int'(busy_o), 0);
    check("R2 start bit idle", int'(start_bit_o), 0);
    m_ra = 7;
    check_state("R2");

    // random mix of dual / separate with compatible and incompatible channels
    for (int i = 0; i < 10; i++) begin
      freq_a_i = 20'($urandom_range(100000, 900000));
      freq_b_i = 20'(int'(freq_a_i) + int'($urandom_range(0, 3000)) - 1500);
      ref_div_a_i = 3'($urandom); ref_div_b_i = ($urandom_range(0, 3) == 0) ? 3'($urandom) : ref_div_a_i;
      vco_cur_a_i = 4'($urandom); vco_cur_b_i = ($urandom_range(0, 3) == 0) ? 4'($urandom) : vco_cur_a_i;
      dual_i = 1'($urandom); chan_sel_i = 1'($urandom); wait_sel_i = 2'($urandom);
      vco_code_i = 6'($urandom); lock_after = 0;
      ok = compat_ok();
      run_cal(len);
      check_len("R3 random", len, units(wait_sel_i) * SCALE, 1);
      if (dual_i && !ok) m_rej = 1;
      if ((dual_i && ok) || !chan_sel_i) begin m_va = 1; m_ra = int'(vco_code_i); end
      if ((dual_i && ok) || chan_sel_i)  begin m_vb = 1; m_rb = int'(vco_code_i); end
      check_state($sformatf("R8 R9 random %0d", i));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule